// File: doc/BRIEF.md
# Ticket Lock Arbiter

This block is a hardware mutual-exclusion unit shared by `N` requesters. It keeps two counters: one that hands out tickets and one that names the ticket now allowed to hold the lock. When a requester asks for the lock, the unit takes the current dispenser value as that requester's ticket and advances the dispenser. This is the only read-modify-write for the acquire, and it happens when the request arrives.

A requester holds the lock while its ticket matches the serving counter. When the holder lets go, the serving counter moves forward by one, and the next ticket in line is granted on the following cycle. Acquires that arrive in the same cycle are ordered by requester index. The lock is therefore handed out strictly in arrival order. Both counters are `W` bits wide and wrap. `W` must be at least `$clog2(N)+1`, so that the at most `N` outstanding tickets never collide.

Top module: `ticket_lock`

## Requirements
- R1: After reset both counters are zero, no grant is asserted and `rel_err_o` is low. The first acquire is granted in the cycle after it is sampled, with ticket 0.
- R2: An acquire from an idle requester `k` stores the dispenser value in slice `k` of `ticket_o` (bits `k*W +: W`), visible the cycle after the acquire. The dispenser then advances by one for each accepted acquire.
- R3: Acquires accepted in the same cycle get consecutive tickets, with the lowest requester index receiving the lowest ticket.
- R4: `grant_o[k]` is high exactly when requester `k` holds a ticket equal to the serving counter. At most one grant bit is high at a time.
- R5: A release from the current holder advances the serving counter by one and clears that requester's grant in the next cycle.
- R6: Grants are issued in strict ticket order, which is also acquisition order.
- R7: An acquire from a requester that already holds a ticket (waiting or granted) is ignored. Its ticket is unchanged and no ticket is consumed.
- R8: A release from a requester whose grant bit is low leaves the grants and counters unchanged. `rel_err_o` goes high for one cycle, in the cycle after that release.
- R9: Both counters wrap modulo 2^W, and the first-come order and the grant compare stay correct across the wrap.
- R10: A granted requester keeps its grant, and its ticket output stays stable, until it releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acq_i | input | N | Acquire request, one bit per requester |
| rel_i | input | N | Release request, one bit per requester |
| grant_o | output | N | Lock held, one bit per requester |
| ticket_o | output | N*W | Ticket of each requester, slice k at bits k*W +: W |
| rel_err_o | output | 1 | Pulse flagging a release from a non-holder |

## Verification
A corrupted dispenser shows up as a duplicated or skipped ticket in `ticket_o` one cycle after the acquire. A skipped ticket stalls the lock with no grant at all, and a duplicated ticket raises two grants at once. A corrupted serving counter shows up in the cycle after a release, either as the wrong requester granted or as no grant. The bench therefore compares every output against a reference model on every cycle, so that a fault is reported in the cycle it first reaches the ports. It runs with a counter width small enough that the wrap happens many times.

// File: rtl/ticket_lock_pkg.sv
package ticket_lock_pkg;
  localparam int unsigned TL_N_DEF = 4;
  localparam int unsigned TL_W_DEF = 3;
endpackage

// File: rtl/ticket_dispenser.sv
module ticket_dispenser #(
  parameter int unsigned N = ticket_lock_pkg::TL_N_DEF,
  parameter int unsigned W = ticket_lock_pkg::TL_W_DEF
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N-1:0]          take_i,
  output logic [N-1:0][W-1:0]   issue_o
);
  logic [W-1:0] next_q, next_d;

  // index order serializes same-cycle takers
  always_comb begin
    next_d = next_q;
    for (int k = 0; k < N; k++) begin
      issue_o[k] = next_d;
      if (take_i[k]) next_d = next_d + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) next_q <= '0;
    else         next_q <= next_d;
  end
endmodule

// File: rtl/serve_counter.sv
module serve_counter #(
  parameter int unsigned N = ticket_lock_pkg::TL_N_DEF,
  parameter int unsigned W = ticket_lock_pkg::TL_W_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  rel_i,
  input  logic [N-1:0]  grant_i,
  output logic [W-1:0]  serving_o,
  output logic          rel_err_o
);
  logic [W-1:0] serving_q;
  logic         err_q;
  logic         rel_ok, rel_bad;

  assign rel_ok  = |(rel_i & grant_i);
  assign rel_bad = |(rel_i & ~grant_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      serving_q <= '0;
      err_q     <= 1'b0;
    end else begin
      if (rel_ok) serving_q <= serving_q + 1'b1;
      err_q <= rel_bad;
    end
  end

  assign serving_o = serving_q;
  assign rel_err_o = err_q;
endmodule

// File: rtl/lock_slot.sv
module lock_slot #(
  parameter int unsigned W = ticket_lock_pkg::TL_W_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acq_i,
  input  logic          rel_i,
  input  logic [W-1:0]  issue_i,
  input  logic [W-1:0]  serving_i,
  output logic          take_o,
  output logic          grant_o,
  output logic [W-1:0]  ticket_o
);
  logic         wait_q;
  logic [W-1:0] ticket_q;

  assign take_o   = acq_i & ~wait_q;
  assign grant_o  = wait_q && (ticket_q == serving_i);
  assign ticket_o = ticket_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q   <= 1'b0;
      ticket_q <= '0;
    end else if (take_o) begin
      wait_q   <= 1'b1;
      ticket_q <= issue_i;
    end else if (rel_i && grant_o) begin
      wait_q   <= 1'b0;
    end
  end
endmodule

// File: rtl/ticket_lock.sv
module ticket_lock #(
  parameter int unsigned N = ticket_lock_pkg::TL_N_DEF,
  parameter int unsigned W = ticket_lock_pkg::TL_W_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    acq_i,
  input  logic [N-1:0]    rel_i,
  output logic [N-1:0]    grant_o,
  output logic [N*W-1:0]  ticket_o,
  output logic            rel_err_o
);
  logic [N-1:0]         take;
  logic [N-1:0][W-1:0]  issue;
  logic [N-1:0][W-1:0]  tkt;
  logic [W-1:0]         serving_q;

  ticket_dispenser #(.N(N), .W(W)) u_disp (
    .clk_i(clk_i), .rst_ni(rst_ni), .take_i(take), .issue_o(issue)
  );

  serve_counter #(.N(N), .W(W)) u_serve (
    .clk_i(clk_i), .rst_ni(rst_ni), .rel_i(rel_i), .grant_i(grant_o),
    .serving_o(serving_q), .rel_err_o(rel_err_o)
  );

  for (genvar k = 0; k < N; k++) begin : g_slot
    lock_slot #(.W(W)) u_slot (
      .clk_i(clk_i), .rst_ni(rst_ni), .acq_i(acq_i[k]), .rel_i(rel_i[k]),
      .issue_i(issue[k]), .serving_i(serving_q),
      .take_o(take[k]), .grant_o(grant_o[k]), .ticket_o(tkt[k])
    );
  end

  assign ticket_o = tkt;
endmodule

// File: rtl/ticket_lock_chk.sv
module ticket_lock_chk #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N-1:0]    acq_i,
  input logic [N-1:0]    rel_i,
  input logic [N-1:0]    grant_o,
  input logic [N*W-1:0]  ticket_o,
  input logic            rel_err_o,
  input logic [W-1:0]    serving
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o)); // R4

  AST_RELEASE_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(rel_i & grant_o) |=> serving == $past(serving) + 1'b1); // R5

  AST_BAD_RELEASE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(rel_i & ~grant_o) |=> rel_err_o); // R8

  AST_BAD_RELEASE_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(rel_i & ~grant_o) && !(|(rel_i & grant_o))) |=> $stable(serving)); // R8

  for (genvar k = 0; k < N; k++) begin : g_hold
    AST_GRANT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_o[k] && !rel_i[k]) |=> grant_o[k] && $stable(ticket_o[k*W +: W])); // R10
  end
endmodule

bind ticket_lock ticket_lock_chk #(.N(N), .W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .acq_i(acq_i), .rel_i(rel_i),
  .grant_o(grant_o), .ticket_o(ticket_o), .rel_err_o(rel_err_o),
  .serving(serving_q)
);

// File: tb/ticket_lock_bench.sv
module ticket_lock_bench;
  localparam int N = 4;
  localparam int W = 3;
  localparam int CLK_PERIOD = 10;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [N-1:0]    acq_i = '0;
  logic [N-1:0]    rel_i = '0;
  logic [N-1:0]    grant_o;
  logic [N*W-1:0]  ticket_o;
  logic            rel_err_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [W-1:0] m_next, m_serv;
  logic [N-1:0] m_wait;
  logic [W-1:0] m_tkt [N];
  logic         m_err;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ticket_lock #(.N(N), .W(W)) u_ticket_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .acq_i(acq_i), .rel_i(rel_i),
    .grant_o(grant_o), .ticket_o(ticket_o), .rel_err_o(rel_err_o)
  );

  function automatic logic [N-1:0] m_grant();
    logic [N-1:0] g;
    for (int k = 0; k < N; k++) g[k] = m_wait[k] && (m_tkt[k] == m_serv);
    return g;
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "grant_o", grant_o, m_grant());
    chk(tag, "rel_err_o", rel_err_o, m_err);
    for (int k = 0; k < N; k++)
      if (m_wait[k]) chk(tag, $sformatf("ticket[%0d]", k), ticket_o[k*W +: W], m_tkt[k]);
  endtask

  task automatic model_step(logic [N-1:0] a, logic [N-1:0] r);
    logic [N-1:0] g;
    g = m_grant();
    m_err = |(r & ~g);
    for (int k = 0; k < N; k++) begin
      if (a[k] && !m_wait[k]) begin
        m_wait[k] = 1'b1;
        m_tkt[k]  = m_next;
        m_next    = m_next + 1'b1;
      end else if (r[k] && g[k]) begin
        m_wait[k] = 1'b0;
      end
    end
    if (|(r & g)) m_serv = m_serv + 1'b1;
  endtask

  // drive at negedge, check at the next negedge
  task automatic step(logic [N-1:0] a, logic [N-1:0] r, string tag);
    acq_i = a;
    rel_i = r;
    model_step(a, r);
    @(negedge clk_i);
    acq_i = '0;
    rel_i = '0;
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_next = '0; m_serv = '0; m_wait = '0; m_err = 1'b0;
    for (int k = 0; k < N; k++) m_tkt[k] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "grant after reset", grant_o, 0);
    chk("R1", "rel_err after reset", rel_err_o, 0);

    // R1 first acquire granted next cycle with ticket 0
    step(4'b0100, '0, "R1");
    chk("R1", "first grant", grant_o, 4'b0100);
    chk("R1", "first ticket", ticket_o[2*W +: W], 0);

    // R3 simultaneous acquires from the other three
    step(4'b1011, '0, "R3");
    chk("R3", "ticket r0", ticket_o[0 +: W], 1);
    chk("R3", "ticket r1", ticket_o[W +: W], 2);
    chk("R3", "ticket r3", ticket_o[3*W +: W], 3);

    // R7 re-acquire by holder and waiters ignored
    step(4'b1111, '0, "R7");
    chk("R7", "holder ticket", ticket_o[2*W +: W], 0);
    chk("R7", "waiter ticket", ticket_o[3*W +: W], 3);

    // R8 release from non-holder
    step('0, 4'b0010, "R8");
    chk("R8", "err pulse", rel_err_o, 1);
    chk("R8", "grant kept", grant_o, 4'b0100);
    step('0, '0, "R8");
    chk("R8", "err clears", rel_err_o, 0);

    // R10 holder keeps grant while idle
    step('0, '0, "R10");
    chk("R10", "grant held", grant_o, 4'b0100);

    // R5 R6 release in ticket order
    step('0, 4'b0100, "R5");
    chk("R6", "second holder", grant_o, 4'b0001);
    step('0, 4'b0001, "R6");
    chk("R6", "third holder", grant_o, 4'b0010);
    step('0, 4'b0010, "R6");
    chk("R6", "fourth holder", grant_o, 4'b1000);
    step('0, 4'b1000, "R5");
    chk("R5", "lock free", grant_o, 0);

    // R9 wrap: cycle tickets past 2^W
    for (int i = 0; i < 12; i++) begin
      step(4'b0001 << (i % N), '0, "R9");
      chk("R9", "wrap grant", grant_o, 4'b0001 << (i % N));
      step('0, 4'b0001 << (i % N), "R9");
    end

    // R2 R4 R6 constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] a, r, g;
      g = m_grant();
      a = '0; r = '0;
      for (int k = 0; k < N; k++) begin
        a[k] = ($urandom % 3) == 0;
        if (g[k]) r[k] = ($urandom % 2) == 0;
        else      r[k] = ($urandom % 20) == 0;
      end
      step(a, r, "R2");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule